// File: doc/BRIEF.md
# Doorbell Mailbox Command Register Interface

This block is a memory-mapped mailbox through which a host hands commands to a device. The host fills a byte-addressable payload buffer, writes a packed command word holding an opcode, a command set and a 20-bit input length, and then sets the doorbell bit in the control register. A small internal engine takes over from there. It looks the set/opcode pair up in a built-in table and checks the input length against what that command requires. It then runs the matching handler over the payload and writes back a return code and an output byte count. Only after that does it drop the doorbell, so the host can tell that the command has finished.

The register bus is a single-cycle little-endian port. Each access carries a byte address and a size code for 1, 2, 4 or 8 bytes, and must be naturally aligned. Write data and read data are right-justified: the addressed bytes sit in the low lanes. Read data appears on the clock after the request and is held until the next read. The register map is: capabilities at 0x00, control at 0x04, command (64 bit) at 0x08, status (64 bit) at 0x10 and background status at 0x18. The payload buffer of 2^PAYLOAD_SHIFT bytes starts at PAYLOAD_BASE (0x20 by default).

Top module: `mbx_mailbox`

## Requirements
- R1: The capabilities word at 0x00 reads 0x0000000B. Bits 4:0 hold the payload size shift (11, for 2048 bytes), and the interrupt-capable and background-capable bits read zero. Host writes to it have no effect.
- R2: Reads of 1, 2, 4 or 8 bytes (size code 0..3) at naturally aligned addresses return the addressed bytes right-justified, with the higher lanes zero. A misaligned read returns zero and a misaligned write changes nothing.
- R3: Host writes to the status register (0x10) and to the background status register (0x18) have no effect. The background status register always reads zero, and the status register changes only when the engine completes a command.
- R4: Control bit 0 is the doorbell, bit 1 the interrupt enable and bit 2 the background-interrupt enable; bits 1 and 2 read back as written. A command starts only when a host write leaves bit 0 set. On completion the status and command registers are updated first, and the doorbell reads 0 afterwards.
- R5: In the command word, bits 7:0 are the opcode, 15:8 the command set and 35:16 the length. On completion the opcode and set read zero, the length holds the output byte count, and bits 63:36 keep the host's value.
- R6: The return code sits in status bits 47:32, and every other status bit is zero. The codes are: success 0x00, background-started 0x01, invalid-input 0x02, unsupported 0x03, internal-error 0x04, busy 0x06, aborted 0x12, invalid-payload-length 0x16.
- R7: A set/opcode pair that is not in the table returns 0x03 with output length 0, and the payload is left unchanged.
- R8: If the input length differs from the length the command requires, the engine returns 0x16 with output length 0, and the handler does not run (the payload is left unchanged).
- R9: Command set 0x01, opcode 0x00 (identify, input 0 bytes) returns success with output 16. It writes payload word 0 = 0x5A5A00010000C0DE and word 1 = 0x0000080000000004 (payload bytes in the upper half, command count in the lower half).
- R10: Command set 0x01, opcode 0x01 (add, input 16 bytes) replaces payload word 0 with word 0 + word 1 and returns success with output 8. If the 64-bit addition carries out, it returns 0x02 with output 0 and leaves the payload unchanged.
- R11: Command set 0x02, opcode 0x00 (no-op, input 0 bytes) returns success with output 0 and leaves the payload unchanged.
- R12: Command set 0x02, opcode 0x01 (clear, input 0 bytes) zeroes payload words 0..7, leaves word 8 and above untouched, and returns success with output 64.
- R13: While the doorbell is set, host writes to the payload, the command register and the control register are ignored.
- R14: The output length written on completion never exceeds the advertised payload size of 2^PAYLOAD_SHIFT bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 2 | Access size: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 |
| bus_wdata | input | 64 | Right-justified write data |
| bus_rdata | output | 64 | Right-justified read data, valid the cycle after a read request |

## Verification
A wrong engine state shows at the ports as a doorbell that never falls, or as a status or command word that disagrees with the command issued. Either can be seen within a few cycles of ringing the doorbell, at the first poll of the control register. A handler that runs when it should not, or a host write that slips through while the doorbell is set, leaves a corrupted payload word that the next read of the buffer exposes. Lane errors in the read path show at once as a wrong byte pattern on a sub-word read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned OFF_CAPS = 'h00;
    localparam int unsigned OFF_CTRL = 'h04;
    localparam int unsigned OFF_CMD  = 'h08;
    localparam int unsigned OFF_STS  = 'h10;
    localparam int unsigned OFF_BGS  = 'h18;

    typedef enum logic [15:0] {
        RC_OK          = 16'h0000,
        RC_BG_STARTED  = 16'h0001,
        RC_BAD_INPUT   = 16'h0002,
        RC_UNSUPPORTED = 16'h0003,
        RC_INTERNAL    = 16'h0004,
        RC_BUSY        = 16'h0006,
        RC_ABORTED     = 16'h0012,
        RC_BAD_LENGTH  = 16'h0016
    } rc_e;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_IDENT,
        CK_SUM,
        CK_NOP,
        CK_CLEAR
    } cmd_kind_e;

    typedef struct packed {
        logic      known;
        cmd_kind_e kind;
        logic [19:0] in_len;
    } cmd_desc_t;

    typedef struct packed {
        logic [27:0] keep;
        logic [19:0] len;
        logic [7:0]  cset;
        logic [7:0]  opc;
    } cmd_word_t;

    localparam logic [63:0] IDENT_W0 = 64'h5A5A_0001_0000_C0DE;
    localparam int unsigned CMD_COUNT = 4;

    function automatic logic [63:0] ident_w1(int unsigned shift);
        return {32'(1 << shift), 32'(CMD_COUNT)};
    endfunction

    function automatic cmd_desc_t lookup(logic [7:0] cset, logic [7:0] opc);
        cmd_desc_t d;
        d = '{known: 1'b0, kind: CK_NONE, in_len: 20'd0};
        case ({cset, opc})
            16'h0100: d = '{known: 1'b1, kind: CK_IDENT, in_len: 20'd0};
            16'h0101: d = '{known: 1'b1, kind: CK_SUM,   in_len: 20'd16};
            16'h0200: d = '{known: 1'b1, kind: CK_NOP,   in_len: 20'd0};
            16'h0201: d = '{known: 1'b1, kind: CK_CLEAR, in_len: 20'd0};
            default:  d = '{known: 1'b0, kind: CK_NONE,  in_len: 20'd0};
        endcase
        return d;
    endfunction

    function automatic logic [63:0] lane_mask(logic [1:0] size);
        case (size)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [7:0] byte_en(logic [2:0] lane, logic [1:0] size);
        logic [7:0] base;
        case (size)
            2'd0:    base = 8'h01;
            2'd1:    base = 8'h03;
            2'd2:    base = 8'h0F;
            default: base = 8'hFF;
        endcase
        return base << lane;
    endfunction

    function automatic logic is_aligned(logic [2:0] lane, logic [1:0] size);
        case (size)
            2'd0:    return 1'b1;
            2'd1:    return lane[0] == 1'b0;
            2'd2:    return lane[1:0] == 2'b00;
            default: return lane == 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             h_we,
    input  logic [IDX_W-1:0] h_idx,
    input  logic [7:0]       h_be,
    input  logic [63:0]      h_wdata,
    output logic [63:0]      h_rdata,
    input  logic             e_we,
    input  logic [IDX_W-1:0] e_widx,
    input  logic [63:0]      e_wdata,
    input  logic [IDX_W-1:0] e_ridx,
    output logic [63:0]      e_rdata
);
    localparam int unsigned WORDS = 1 << IDX_W;

    logic [63:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (h_we) begin
            for (int b = 0; b < 8; b++) begin
                if (h_be[b]) begin
                    mem[h_idx][8*b +: 8] <= h_wdata[8*b +: 8];
                end
            end
        end
        if (e_we) begin
            mem[e_widx] <= e_wdata;
        end
    end

    assign h_rdata = mem[h_idx];
    assign e_rdata = mem[e_ridx];

endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
    import mbx_pkg::*;
#(
    parameter int unsigned PAYLOAD_SHIFT = 11,
    parameter int unsigned IDX_W         = 8,
    parameter int unsigned CLEAR_WORDS   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             db,
    input  logic [7:0]       cmd_set,
    input  logic [7:0]       cmd_opc,
    input  logic [19:0]      cmd_len,
    input  logic [63:0]      rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [63:0]      wr_data,
    output logic             sts_we,
    output logic [15:0]      rc_out,
    output logic [19:0]      len_out,
    output logic             db_drop,
    output logic             idle
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN, S_DROP} st_e;

    localparam logic [19:0]      CLEAR_BYTES = 20'(CLEAR_WORDS * 8);
    localparam logic [IDX_W-1:0] CLEAR_LAST  = IDX_W'(CLEAR_WORDS - 1);
    localparam logic [IDX_W-1:0] IDENT_LAST  = IDX_W'(1);

    st_e              st;
    cmd_kind_e        kind;
    logic [IDX_W-1:0] step;
    logic [63:0]      acc;
    logic [15:0]      rc_q;
    logic [19:0]      len_q;
    cmd_desc_t        desc;
    logic [64:0]      sum;

    assign desc = lookup(cmd_set, cmd_opc);
    assign sum  = {1'b0, acc} + {1'b0, rd_data};

    always_comb begin
        rd_idx  = step;
        wr_en   = 1'b0;
        wr_idx  = step;
        wr_data = '0;
        if (st == S_RUN) begin
            case (kind)
                CK_IDENT: begin
                    wr_en   = 1'b1;
                    wr_data = (step == '0) ? IDENT_W0 : ident_w1(PAYLOAD_SHIFT);
                end
                CK_SUM: begin
                    if (step != '0 && !sum[64]) begin
                        wr_en   = 1'b1;
                        wr_idx  = '0;
                        wr_data = sum[63:0];
                    end
                end
                CK_CLEAR: begin
                    wr_en = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            kind  <= CK_NONE;
            step  <= '0;
            acc   <= '0;
            rc_q  <= '0;
            len_q <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (db) begin
                        step <= '0;
                        kind <= desc.kind;
                        if (!desc.known) begin
                            rc_q  <= RC_UNSUPPORTED;
                            len_q <= '0;
                            st    <= S_FIN;
                        end else if (cmd_len != desc.in_len) begin
                            rc_q  <= RC_BAD_LENGTH;
                            len_q <= '0;
                            st    <= S_FIN;
                        end else begin
                            st <= S_RUN;
                        end
                    end
                end
                S_RUN: begin
                    case (kind)
                        CK_IDENT: begin
                            if (step == IDENT_LAST) begin
                                rc_q  <= RC_OK;
                                len_q <= 20'd16;
                                st    <= S_FIN;
                            end else begin
                                step <= step + 1'b1;
                            end
                        end
                        CK_SUM: begin
                            if (step == '0) begin
                                acc  <= rd_data;
                                step <= IDX_W'(1);
                            end else begin
                                if (sum[64]) begin
                                    rc_q  <= RC_BAD_INPUT;
                                    len_q <= '0;
                                end else begin
                                    rc_q  <= RC_OK;
                                    len_q <= 20'd8;
                                end
                                st <= S_FIN;
                            end
                        end
                        CK_NOP: begin
                            rc_q  <= RC_OK;
                            len_q <= '0;
                            st    <= S_FIN;
                        end
                        CK_CLEAR: begin
                            if (step == CLEAR_LAST) begin
                                rc_q  <= RC_OK;
                                len_q <= CLEAR_BYTES;
                                st    <= S_FIN;
                            end else begin
                                step <= step + 1'b1;
                            end
                        end
                        default: begin
                            rc_q  <= RC_INTERNAL;
                            len_q <= '0;
                            st    <= S_FIN;
                        end
                    endcase
                end
                S_FIN:   st <= S_DROP;
                S_DROP:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign sts_we  = (st == S_FIN);
    assign db_drop = (st == S_DROP);
    assign idle    = (st == S_IDLE);
    assign rc_out  = rc_q;
    assign len_out = len_q;

endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned PAYLOAD_SHIFT = 11,
    parameter int unsigned PAYLOAD_BASE  = 'h20,
    parameter int unsigned CLEAR_WORDS   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata
);
    localparam int unsigned PAY_BYTES = 1 << PAYLOAD_SHIFT;
    localparam int unsigned WORDS     = PAY_BYTES / 8;
    localparam int unsigned IDX_W     = $clog2(WORDS);
    localparam int unsigned DW_W      = ADDR_W - 3;
    localparam logic [DW_W-1:0] DW_CTRL = DW_W'(OFF_CTRL >> 3);
    localparam logic [DW_W-1:0] DW_CMD  = DW_W'(OFF_CMD >> 3);
    localparam logic [DW_W-1:0] DW_STS  = DW_W'(OFF_STS >> 3);
    localparam logic [DW_W-1:0] DW_BGS  = DW_W'(OFF_BGS >> 3);
    localparam int unsigned CTRL_LANE = OFF_CTRL % 8;
    localparam logic [31:0] CAPS_WORD = {27'd0, 5'(PAYLOAD_SHIFT)};

    logic        db_q, ie_q, bie_q;
    cmd_word_t   cmd_q;
    logic [15:0] rc_q;
    logic [63:0] rdata_q;

    logic [2:0]        lane;
    logic [DW_W-1:0]   dw;
    logic              acc_ok;
    logic              in_pay;
    logic [ADDR_W-1:0] pay_off;
    logic [IDX_W-1:0]  pay_idx;
    logic [7:0]        be;
    logic [63:0]       wsh;
    logic              host_wr;
    logic [63:0]       h_rdata;
    logic [63:0]       rd_dw;
    logic [63:0]       rd_next;

    logic             eng_wr_en;
    logic [IDX_W-1:0] eng_wr_idx;
    logic [63:0]      eng_wr_data;
    logic [IDX_W-1:0] eng_rd_idx;
    logic [63:0]      eng_rd_data;
    logic             eng_sts_we;
    logic [15:0]      eng_rc;
    logic [19:0]      eng_len;
    logic             eng_drop;
    logic             eng_idle;

    assign lane    = bus_addr[2:0];
    assign dw      = bus_addr[ADDR_W-1:3];
    assign acc_ok  = is_aligned(lane, bus_size);
    assign in_pay  = (32'(bus_addr) >= PAYLOAD_BASE) &&
                     (32'(bus_addr) < PAYLOAD_BASE + PAY_BYTES);
    assign pay_off = bus_addr - ADDR_W'(PAYLOAD_BASE);
    assign pay_idx = IDX_W'(pay_off >> 3);
    assign be      = byte_en(lane, bus_size);
    assign wsh     = (bus_wdata & lane_mask(bus_size)) << {lane, 3'b000};
    assign host_wr = bus_valid && bus_write && acc_ok && !db_q;

    mbx_store #(
        .IDX_W(IDX_W)
    ) u_store (
        .clk     (clk),
        .h_we    (host_wr && in_pay),
        .h_idx   (pay_idx),
        .h_be    (be),
        .h_wdata (wsh),
        .h_rdata (h_rdata),
        .e_we    (eng_wr_en),
        .e_widx  (eng_wr_idx),
        .e_wdata (eng_wr_data),
        .e_ridx  (eng_rd_idx),
        .e_rdata (eng_rd_data)
    );

    mbx_engine #(
        .PAYLOAD_SHIFT(PAYLOAD_SHIFT),
        .IDX_W        (IDX_W),
        .CLEAR_WORDS  (CLEAR_WORDS)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .db      (db_q),
        .cmd_set (cmd_q.cset),
        .cmd_opc (cmd_q.opc),
        .cmd_len (cmd_q.len),
        .rd_data (eng_rd_data),
        .rd_idx  (eng_rd_idx),
        .wr_en   (eng_wr_en),
        .wr_idx  (eng_wr_idx),
        .wr_data (eng_wr_data),
        .sts_we  (eng_sts_we),
        .rc_out  (eng_rc),
        .len_out (eng_len),
        .db_drop (eng_drop),
        .idle    (eng_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            db_q  <= 1'b0;
            ie_q  <= 1'b0;
            bie_q <= 1'b0;
            cmd_q <= '0;
            rc_q  <= '0;
        end else begin
            if (host_wr && !in_pay) begin
                if (dw == DW_CTRL && be[CTRL_LANE]) begin
                    {bie_q, ie_q, db_q} <= wsh[8*CTRL_LANE +: 3];
                end
                if (dw == DW_CMD) begin
                    for (int b = 0; b < 8; b++) begin
                        if (be[b]) begin
                            cmd_q[8*b +: 8] <= wsh[8*b +: 8];
                        end
                    end
                end
            end
            if (eng_sts_we) begin
                cmd_q.cset <= '0;
                cmd_q.opc  <= '0;
                cmd_q.len  <= eng_len;
                rc_q       <= eng_rc;
            end
            if (eng_drop) begin
                db_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_dw = '0;
        if (in_pay) begin
            rd_dw = h_rdata;
        end else begin
            case (dw)
                DW_CTRL: rd_dw = {29'd0, bie_q, ie_q, db_q, CAPS_WORD};
                DW_CMD:  rd_dw = cmd_q;
                DW_STS:  rd_dw = {16'd0, rc_q, 32'd0};
                DW_BGS:  rd_dw = '0;
                default: rd_dw = '0;
            endcase
        end
    end

    assign rd_next = acc_ok ? ((rd_dw >> {lane, 3'b000}) & lane_mask(bus_size)) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_valid && !bus_write) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
    parameter int unsigned PAYLOAD_SHIFT = 11
) (
    input logic        clk,
    input logic        rst,
    input logic        db,
    input logic        eng_idle,
    input logic        sts_we,
    input logic [35:0] cmd_low,
    input logic [15:0] rc
);
    localparam int unsigned PAY_BYTES = 1 << PAYLOAD_SHIFT;

    AST_STS_BEFORE_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(db) |-> $past(sts_we, 2)) else $error("doorbell fell without status update"); // R4

    AST_IDLE_WITHOUT_DB: assert property (@(posedge clk) disable iff (rst)
        !db |-> eng_idle) else $error("engine busy with doorbell clear"); // R4

    AST_STS_ONLY_ENGINE: assert property (@(posedge clk) disable iff (rst)
        !sts_we |=> $stable(rc)) else $error("status changed outside completion"); // R3

    AST_CMD_FIELDS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $fell(db) |-> cmd_low[15:0] == 16'h0) else $error("set/opcode not cleared"); // R5

    AST_BADLEN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        ($fell(db) && rc == 16'h0016) |-> cmd_low[35:16] == 20'd0) else $error("length error with output"); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        $fell(db) |-> 32'(cmd_low[35:16]) <= PAY_BYTES) else $error("output length too large"); // R14

endmodule

bind mbx_mailbox mbx_mailbox_chk #(
    .PAYLOAD_SHIFT(PAYLOAD_SHIFT)
) u_mbx_chk (
    .clk      (clk),
    .rst      (rst),
    .db       (db_q),
    .eng_idle (eng_idle),
    .sts_we   (eng_sts_we),
    .cmd_low  (cmd_q[35:0]),
    .rc       (rc_q)
);

// File: tb/test_mbx_mailbox.sv
module test_mbx_mailbox;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [63:0] pm [16];

    localparam logic [63:0] ID0 = 64'h5A5A_0001_0000_C0DE;
    localparam logic [63:0] ID1 = {32'd2048, 32'd4};

    always #2 clk = ~clk;

    mbx_mailbox i_mbx_mailbox (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [63:0] bmask(logic [1:0] s);
        case (s)
            2'd0: return 64'hFF;
            2'd1: return 64'hFFFF;
            2'd2: return 64'hFFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [1:0] s, logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, logic [1:0] s, output logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = s;
        @(posedge clk);
        #1 bus_valid = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic model_wr(int idx, int lane, logic [1:0] s, logic [63:0] d);
        for (int b = 0; b < (1 << s); b++) begin
            pm[idx][8*(lane+b) +: 8] = d[8*b +: 8];
        end
    endtask

    task automatic wait_done();
        logic [63:0] v;
        v = 64'h1;
        for (int i = 0; i < 100 && v[0]; i++) begin
            rd(12'h4, 2'd0, v);
        end
        chk("R4 doorbell cleared", {63'd0, v[0]}, 64'd0);
    endtask

    task automatic run_cmd(logic [7:0] cs, logic [7:0] op, logic [19:0] len, logic [27:0] keep);
        logic [63:0] v;
        logic [15:0] rc;
        logic [19:0] outl;
        logic [64:0] s;
        string ptag;
        rc = 16'h0; outl = 20'd0;
        wr(12'h8, 2'd3, {keep, len, cs, op});
        wr(12'h4, 2'd2, 64'h1);
        wait_done();
        case ({cs, op})
            16'h0100: begin
                ptag = "R9";
                if (len != 20'd0) begin rc = 16'h16; ptag = "R8"; end
                else begin outl = 20'd16; pm[0] = ID0; pm[1] = ID1; end
            end
            16'h0101: begin
                ptag = "R10";
                if (len != 20'd16) begin rc = 16'h16; ptag = "R8"; end
                else begin
                    s = {1'b0, pm[0]} + {1'b0, pm[1]};
                    if (s[64]) rc = 16'h02;
                    else begin pm[0] = s[63:0]; outl = 20'd8; end
                end
            end
            16'h0200: begin
                ptag = "R11";
                if (len != 20'd0) begin rc = 16'h16; ptag = "R8"; end
            end
            16'h0201: begin
                ptag = "R12";
                if (len != 20'd0) begin rc = 16'h16; ptag = "R8"; end
                else begin
                    outl = 20'd64;
                    for (int i = 0; i < 8; i++) pm[i] = '0;
                end
            end
            default: begin ptag = "R7"; rc = 16'h03; end
        endcase
        rd(12'h8, 2'd3, v);
        chk({ptag, " R5 command word after completion"}, v, {keep, outl, 16'h0});
        rd(12'h10, 2'd3, v);
        chk({ptag, " R6 status word"}, v, {16'h0, rc, 32'h0});
        rd(12'h14, 2'd1, v);
        chk({ptag, " R6 return code halfword"}, v, {48'h0, rc});
        for (int i = 0; i < 10; i++) begin
            rd(12'(32'h20 + 8*i), 2'd3, v);
            chk({ptag, " payload word"}, v, pm[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'd20240));
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        rd(12'h0, 2'd2, v); chk("R1 caps after reset", v, 64'hB);
        rd(12'h4, 2'd2, v); chk("R4 control after reset", v, 64'h0);
        rd(12'h10, 2'd3, v); chk("R3 status after reset", v, 64'h0);
        rd(12'h18, 2'd3, v); chk("R3 background status after reset", v, 64'h0);

        wr(12'h0, 2'd2, 64'hFFFF_FFFF);
        rd(12'h0, 2'd2, v); chk("R1 caps write ignored", v, 64'hB);
        wr(12'h10, 2'd3, '1);
        rd(12'h10, 2'd3, v); chk("R3 status write ignored", v, 64'h0);
        wr(12'h18, 2'd3, '1);
        rd(12'h18, 2'd3, v); chk("R3 background status write ignored", v, 64'h0);

        wr(12'h4, 2'd0, 64'h6);
        rd(12'h4, 2'd0, v); chk("R4 enable bits read back", v, 64'h6);
        rd(12'h10, 2'd3, v); chk("R4 no command without doorbell", v, 64'h0);
        wr(12'h4, 2'd0, 64'h0);

        for (int i = 0; i < 16; i++) begin
            pm[i] = {$urandom, $urandom};
            wr(12'(32'h20 + 8*i), 2'd3, pm[i]);
        end
        for (int i = 0; i < 40; i++) begin
            int idx, ln;
            logic [1:0] s;
            logic [63:0] d;
            idx = int'($urandom % 16);
            s = 2'($urandom % 4);
            ln = int'($urandom % 8) & ~((1 << s) - 1);
            d = {$urandom, $urandom};
            wr(12'(32'h20 + 8*idx + ln), s, d);
            model_wr(idx, ln, s, d);
        end
        for (int i = 0; i < 60; i++) begin
            int idx, ln;
            logic [1:0] s;
            idx = int'($urandom % 16);
            s = 2'($urandom % 4);
            ln = int'($urandom % 8) & ~((1 << s) - 1);
            rd(12'(32'h20 + 8*idx + ln), s, v);
            chk("R2 sized payload read", v, (pm[idx] >> (8*ln)) & bmask(s));
        end
        rd(12'h21, 2'd1, v); chk("R2 misaligned read is zero", v, 64'h0);
        wr(12'h22, 2'd2, '1);
        rd(12'h20, 2'd3, v); chk("R2 misaligned write ignored", v, pm[0]);

        wr(12'h8, 2'd3, 64'h0000_000F_1234_0307);
        rd(12'h9, 2'd0, v); chk("R2 R5 command set byte", v, 64'h03);
        rd(12'hA, 2'd1, v); chk("R2 R5 command halfword", v, 64'h1234);
        rd(12'hC, 2'd2, v); chk("R2 R5 command upper word", v, 64'h0000_000F);

        run_cmd(8'h01, 8'h00, 20'd0, 28'hABCDEF1);
        pm[0] = 64'd1000; pm[1] = 64'd2345;
        wr(12'h20, 2'd3, pm[0]); wr(12'h28, 2'd3, pm[1]);
        run_cmd(8'h01, 8'h01, 20'd16, 28'h0);
        pm[0] = '1; pm[1] = 64'd2;
        wr(12'h20, 2'd3, pm[0]); wr(12'h28, 2'd3, pm[1]);
        run_cmd(8'h01, 8'h01, 20'd16, 28'h5);
        run_cmd(8'h02, 8'h00, 20'd0, 28'hFFFFFFF);
        run_cmd(8'h02, 8'h01, 20'd0, 28'h1);
        run_cmd(8'h03, 8'h00, 20'd0, 28'h2);
        run_cmd(8'h01, 8'h05, 20'd0, 28'h3);
        run_cmd(8'h01, 8'h01, 20'd8, 28'h4);
        run_cmd(8'h02, 8'h01, 20'd4, 28'h6);
        run_cmd(8'h01, 8'h00, 20'hFFFFF, 28'h7);

        wr(12'h8, 2'd3, {28'h0, 20'd0, 8'h02, 8'h00});
        wr(12'h4, 2'd2, 64'h1);
        wr(12'h68, 2'd3, 64'hDEAD_BEEF_DEAD_BEEF);
        wr(12'h8, 2'd3, 64'h0000_0001_0000_0101);
        wr(12'h20, 2'd0, 64'h77);
        wait_done();
        rd(12'h8, 2'd3, v); chk("R13 command write ignored while busy", v, 64'h0);
        rd(12'h68, 2'd3, v); chk("R13 payload word 9 unchanged", v, pm[9]);
        rd(12'h20, 2'd3, v); chk("R13 payload word 0 unchanged", v, pm[0]);

        for (int i = 0; i < 60; i++) begin
            logic [7:0] cs, op;
            logic [19:0] len;
            int r;
            cs = 8'(1 + $urandom % 3);
            op = 8'($urandom % 3);
            r = int'($urandom % 4);
            len = (r == 0) ? 20'd0 : (r == 1) ? 20'd16 : (r == 2) ? 20'd8 : 20'($urandom);
            if ($urandom % 3 == 0) begin
                pm[0] = ($urandom % 2) ? {32'd0, $urandom} : {$urandom, $urandom};
                pm[1] = ($urandom % 2) ? {32'd0, $urandom} : {$urandom, $urandom};
                wr(12'h20, 2'd3, pm[0]); wr(12'h28, 2'd3, pm[1]);
            end
            run_cmd(cs, op, len, 28'($urandom));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule